// File: doc/BRIEF.md
# Hardware-Triggered Timer Start Controller

This block is an up-counting timer whose start is controlled by a slave-mode controller. The controller does not wait for software to enable counting. It watches a selected trigger source and, in event mode, sets the counter-enable bit on that source's rising edge. There are two sources. One is an external capture pin, which is first synchronized and edge-detected. The other is an internal trigger line driven by another timer's trigger output.

Timers can be chained. The timer at the head of the chain drives its trigger output into the internal trigger input of the next timer. When the master/slave delay option is set on the head timer, its own start is held back by one cycle. Master and slave then set their enable bit on the same clock edge and count in lockstep from the same value. Software can also set or clear the enable bit and clear the trigger flag. All configuration pins are plain levels or single-cycle write strobes. The block carries no data stream, so there is no valid/ready handshake.

Top module: `trig_start_timer`

## Requirements
- R1: While reset is asserted and directly after it, `count` is 0 and `cen`, `trig_flag` and `trig_out` are all 0.
- R2: With `cfg_trig_sel` = 3'b100, `cfg_slave_mode` = 3'b110 and `cfg_ms_en` = 0, a 0-to-1 change on `ci0_in` sets `cen` on the third rising clock edge that samples `ci0_in` high (two synchronizer stages plus the edge register). `cen` is still 0 after the second such edge.
- R3: With `cfg_trig_sel` = 3'b010, `cfg_slave_mode` = 3'b110 and `cfg_ms_en` = 0, `cen` and `trig_flag` are set on the first rising edge at which `itr_in` is sampled high after being low. Holding `itr_in` high produces no further trigger.
- R4: Every start request pulses `trig_out` high for the cycle after the request edge. A start request is an accepted trigger or `sw_cen_set`. When `cfg_ms_en` = 1, `cen` and `trig_flag` are set one cycle later than with `cfg_ms_en` = 0. A slave timer fed by `trig_out` then sets `cen` on the same edge as the master.
- R5: While `cen` is 1, `count` increases by 1 per clock and wraps from 16'hFFFF to 0. While `cen` is 0, `count` holds its value.
- R6: Once `cen` is set, further accepted triggers do not restart or reset `count`.
- R7: `trig_flag` is set by every accepted trigger and stays set until `sw_flag_clr` is pulsed. If a flag-setting trigger and `sw_flag_clr` land on the same edge, the flag stays set.
- R8: Trigger select codes other than 3'b010 and 3'b100 select no trigger. Slave modes other than 3'b110 disable triggering. In both cases an edge sets neither `cen` nor `trig_flag` and does not pulse `trig_out`.
- R9: `sw_cen_set` sets `cen`, subject to the same master/slave delay as a trigger. `sw_cen_clr` clears `cen`. If set and clear take effect on the same edge, `cen` ends up 1.
- R10: After a chained start, master and slave `count` values are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trig_sel | input | 3 | Trigger source select (3'b010 internal line, 3'b100 capture pin) |
| cfg_slave_mode | input | 3 | Slave mode (3'b110 event mode, anything else off) |
| cfg_ms_en | input | 1 | Master/slave delay enable |
| sw_cen_set | input | 1 | Single-cycle software request to set the counter enable |
| sw_cen_clr | input | 1 | Single-cycle software request to clear the counter enable |
| sw_flag_clr | input | 1 | Single-cycle software clear of the trigger flag |
| ci0_in | input | 1 | Asynchronous external capture input |
| itr_in | input | 1 | Internal trigger from another timer's `trig_out` |
| trig_out | output | 1 | One-cycle start pulse for chained timers |
| count | output | 16 | Counter value |
| cen | output | 1 | Counter enable bit |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The hardest situation to reach is two timers starting on one edge. This needs the delayed master path, the registered trigger output and the slave's edge detector to line up exactly. The bench therefore instantiates a second copy wired as a slave behind the device under test and compares enable and count of both, cycle by cycle, from the capture-pin edge onward. Two same-edge collisions are also driven on purpose: a flag clear together with a trigger, and an enable set together with an enable clear. The sixteen-bit wrap is reached by letting the counter run through its full range.

// File: rtl/tst_pkg.sv
package tst_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned MODE_W = 3;

  localparam logic [SEL_W-1:0]  TSEL_ITR    = 3'b010;
  localparam logic [SEL_W-1:0]  TSEL_CI0    = 3'b100;
  localparam logic [MODE_W-1:0] SMODE_OFF   = 3'b000;
  localparam logic [MODE_W-1:0] SMODE_EVENT = 3'b110;

  typedef struct packed {
    logic cen_set;
    logic flag_set;
  } start_evt_t;
endpackage

// File: rtl/tst_edge_sync.sv
module tst_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  generate
    if (STAGES == 0) begin : g_direct
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
      end
      assign rise = din & ~prev_q;
    end else begin : g_sync
      logic [STAGES:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], din};
      end
      assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/tst_slave_ctrl.sv
module tst_slave_ctrl
  import tst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [MODE_W-1:0] slave_mode,
  input  logic              ms_en,
  input  logic              sw_set,
  input  logic              flag_clr,
  input  logic              ci0_rise,
  input  logic              itr_rise,
  output start_evt_t        evt,
  output logic              flag,
  output logic              trig_out
);
  logic src_edge;
  logic accepted;
  logic start_req;
  logic pend_cen_q, pend_flag_q, trig_q, flag_q;

  always_comb begin
    case (trig_sel)
      TSEL_CI0: src_edge = ci0_rise;
      TSEL_ITR: src_edge = itr_rise;
      default:  src_edge = 1'b0;
    endcase
  end

  assign accepted  = (slave_mode == SMODE_EVENT) && src_edge;
  assign start_req = accepted | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cen_q  <= 1'b0;
      pend_flag_q <= 1'b0;
      trig_q      <= 1'b0;
    end else begin
      pend_cen_q  <= start_req;
      pend_flag_q <= accepted;
      trig_q      <= start_req;
    end
  end

  assign evt.cen_set  = ms_en ? pend_cen_q  : start_req;
  assign evt.flag_set = ms_en ? pend_flag_q : accepted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (evt.flag_set) flag_q <= 1'b1;
    else if (flag_clr)     flag_q <= 1'b0;
  end

  assign flag     = flag_q;
  assign trig_out = trig_q;
endmodule

// File: rtl/tst_counter.sv
module tst_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_set,
  input  logic             cen_clr,
  output logic             cen,
  output logic [CNT_W-1:0] count
);
  logic             cen_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cen_q <= 1'b0;
    else if (cen_set) cen_q <= 1'b1;
    else if (cen_clr) cen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (cen_q) cnt_q <= cnt_q + 1'b1;
  end

  assign cen   = cen_q;
  assign count = cnt_q;
endmodule

// File: rtl/trig_start_timer.sv
module trig_start_timer
  import tst_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_trig_sel,
  input  logic [MODE_W-1:0] cfg_slave_mode,
  input  logic              cfg_ms_en,
  input  logic              sw_cen_set,
  input  logic              sw_cen_clr,
  input  logic              sw_flag_clr,
  input  logic              ci0_in,
  input  logic              itr_in,
  output logic              trig_out,
  output logic [CNT_W-1:0]  count,
  output logic              cen,
  output logic              trig_flag
);
  logic       ci0_rise;
  logic       itr_rise;
  start_evt_t evt;

  tst_edge_sync #(.STAGES(SYNC_LEN)) u_ci0_sync (
    .clk(clk), .rst_n(rst_n), .din(ci0_in), .rise(ci0_rise)
  );

  tst_edge_sync #(.STAGES(0)) u_itr_edge (
    .clk(clk), .rst_n(rst_n), .din(itr_in), .rise(itr_rise)
  );

  tst_slave_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trig_sel(cfg_trig_sel), .slave_mode(cfg_slave_mode), .ms_en(cfg_ms_en),
    .sw_set(sw_cen_set), .flag_clr(sw_flag_clr),
    .ci0_rise(ci0_rise), .itr_rise(itr_rise),
    .evt(evt), .flag(trig_flag), .trig_out(trig_out)
  );

  tst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .cen_set(evt.cen_set), .cen_clr(sw_cen_clr),
    .cen(cen), .count(count)
  );
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_slave_mode,
  input logic             sw_cen_set,
  input logic             sw_cen_clr,
  input logic             sw_flag_clr,
  input logic             trig_out,
  input logic [CNT_W-1:0] count,
  input logic             cen,
  input logic             trig_flag
);
  // R5: one step per enabled cycle, modulo wrap
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cen |=> count == $past(count) + 1'b1);

  // R5: frozen while disabled
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cen |=> count == $past(count));

  // R6: enable only drops through software clear
  p_cen_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && !sw_cen_clr) |=> cen);

  // R7: flag only drops through software clear
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !sw_flag_clr) |=> trig_flag);

  // R8: mode off and no software start means no start pulse
  p_no_pulse_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_slave_mode != 3'b110 && !sw_cen_set) |=> !trig_out);
endmodule

bind trig_start_timer tst_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_slave_mode(cfg_slave_mode),
  .sw_cen_set(sw_cen_set), .sw_cen_clr(sw_cen_clr), .sw_flag_clr(sw_flag_clr),
  .trig_out(trig_out), .count(count), .cen(cen), .trig_flag(trig_flag)
);

// File: tb/trig_start_timer_tb.sv
module trig_start_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000, mode = 3'b000;
  logic       ms = 1'b0, cset = 1'b0, cclr = 1'b0, fclr = 1'b0;
  logic       ci0 = 1'b0, itr = 1'b0;
  logic        trig_out, cen, flag;
  logic [15:0] count;
  logic        s_trig, s_cen, s_flag;
  logic [15:0] s_count;

  int total = 0, bad = 0;
  bit cmp_on = 1'b0, finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_start_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_trig_sel(sel), .cfg_slave_mode(mode),
    .cfg_ms_en(ms), .sw_cen_set(cset), .sw_cen_clr(cclr), .sw_flag_clr(fclr),
    .ci0_in(ci0), .itr_in(itr), .trig_out(trig_out), .count(count),
    .cen(cen), .trig_flag(flag)
  );

  // slave timer chained behind the device under test
  trig_start_timer u_slave (
    .clk(clk), .rst_n(rst_n), .cfg_trig_sel(3'b010), .cfg_slave_mode(3'b110),
    .cfg_ms_en(1'b0), .sw_cen_set(1'b0), .sw_cen_clr(1'b0), .sw_flag_clr(1'b0),
    .ci0_in(1'b0), .itr_in(trig_out), .trig_out(s_trig), .count(s_count),
    .cen(s_cen), .trig_flag(s_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // behavioural reference for the device under test
  bit ci_hist[$];
  bit m_itr_prev, m_pc, m_pf, m_cen, m_flag, m_to;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci_hist = '{0, 0, 0};
      m_itr_prev = 0; m_pc = 0; m_pf = 0; m_cen = 0; m_flag = 0; m_to = 0;
      m_cnt = 0;
    end else begin
      bit rise_ci, rise_itr, acc, start, cs, fs;
      rise_ci  = ci_hist[1] && !ci_hist[2];
      rise_itr = itr && !m_itr_prev;
      ci_hist.push_front(ci0);
      void'(ci_hist.pop_back());
      m_itr_prev = itr;
      acc   = (mode == 3'b110) &&
              ((sel == 3'b100 && rise_ci) || (sel == 3'b010 && rise_itr));
      start = acc || cset;
      cs    = ms ? m_pc : start;
      fs    = ms ? m_pf : acc;
      if (m_cen) m_cnt = (m_cnt + 1) % 65536;
      if (cs) m_cen = 1; else if (cclr) m_cen = 0;
      if (fs) m_flag = 1; else if (fclr) m_flag = 0;
      m_to = start; m_pc = start; m_pf = acc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !finished) begin
      chk(count == 16'(m_cnt), "R5", "model count", int'(count), m_cnt);
      chk(cen == m_cen, "R9", "model cen", int'(cen), int'(m_cen));
      chk(flag == m_flag, "R7", "model flag", int'(flag), int'(m_flag));
      chk(trig_out == m_to, "R4", "model trig_out", int'(trig_out), int'(m_to));
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    tick(3);
    // R1 reset state
    chk(count == 0 && s_count == 0, "R1", "count in reset", int'(count), 0);
    chk(!cen && !flag && !trig_out, "R1", "cen/flag/trig in reset",
        int'({cen, flag, trig_out}), 0);
    rst_n = 1'b1;
    tick(1);
    chk(count == 0 && !cen && !flag && !trig_out, "R1", "after reset",
        int'({cen, flag, trig_out}), 0);
    cmp_on = 1'b1;

    // R2, R4, R10 chained start via capture pin with master/slave delay
    sel = 3'b100; mode = 3'b110; ms = 1'b1;
    ci0 = 1'b1;
    tick(2);
    chk(!cen, "R2", "cen before edge detected", int'(cen), 0);
    tick(1);
    chk(trig_out == 1'b1, "R4", "start pulse", int'(trig_out), 1);
    chk(!cen, "R4", "master delayed", int'(cen), 0);
    tick(1);
    chk(cen && s_cen, "R4", "master and slave start together",
        int'({cen, s_cen}), 3);
    chk(flag && s_flag, "R4", "both flags set", int'({flag, s_flag}), 3);
    chk(!trig_out, "R4", "pulse one cycle", int'(trig_out), 0);
    for (int i = 0; i < 6; i++) begin
      tick(1);
      chk(count == s_count, "R10", "lockstep count", int'(s_count), int'(count));
    end
    chk(count == 16'd6, "R5", "count after 6", int'(count), 6);

    // R6 retrigger leaves count running
    ci0 = 1'b0;
    tick(3);
    c0 = int'(count);
    ci0 = 1'b1;
    tick(7);
    chk(cen && count == 16'(c0 + 7), "R6", "no restart on retrigger",
        int'(count), c0 + 7);

    // R9 clear, R5 hold
    cclr = 1'b1; tick(1); cclr = 1'b0;
    chk(!cen, "R9", "software clear", int'(cen), 0);
    c0 = int'(count);
    tick(3);
    chk(count == 16'(c0), "R5", "hold while off", int'(count), c0);
    fclr = 1'b1; tick(1); fclr = 1'b0;
    chk(!flag, "R7", "flag cleared", int'(flag), 0);

    // R3 internal trigger, R7 set beats clear
    ms = 1'b0; sel = 3'b010; ci0 = 1'b0;
    itr = 1'b1; fclr = 1'b1;
    tick(1);
    fclr = 1'b0;
    chk(cen == 1'b1, "R3", "cen on internal edge", int'(cen), 1);
    chk(flag == 1'b1, "R7", "set wins over clear", int'(flag), 1);
    tick(1);
    fclr = 1'b1; tick(1); fclr = 1'b0;
    tick(1);
    chk(!flag, "R3", "held line gives no new trigger", int'(flag), 0);
    itr = 1'b0;

    // R9 set wins over clear
    cclr = 1'b1; tick(1);
    chk(!cen, "R9", "cleared", int'(cen), 0);
    cset = 1'b1; tick(1); cset = 1'b0; cclr = 1'b0;
    chk(cen && trig_out, "R9", "set wins, pulse", int'({cen, trig_out}), 3);
    tick(1);
    chk(!trig_out, "R9", "pulse ends", int'(trig_out), 0);
    cclr = 1'b1; tick(1); cclr = 1'b0;
    fclr = 1'b1; tick(1); fclr = 1'b0;

    // R8 unimplemented select and disabled modes
    sel = 3'b111; mode = 3'b110;
    itr = 1'b1; ci0 = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk(!cen && !flag && !trig_out, "R8", "bad select ignored",
          int'({cen, flag, trig_out}), 0);
    end
    itr = 1'b0; tick(1);
    sel = 3'b010; mode = 3'b101; itr = 1'b1;
    tick(2);
    chk(!cen && !flag && !trig_out, "R8", "mode 101 ignored",
        int'({cen, flag, trig_out}), 0);
    itr = 1'b0; tick(1);
    mode = 3'b000; itr = 1'b1;
    tick(2);
    chk(!cen && !flag && !trig_out, "R8", "mode off ignored",
        int'({cen, flag, trig_out}), 0);
    itr = 1'b0;

    // R5 wrap
    cset = 1'b1; tick(1); cset = 1'b0;
    for (int i = 0; i < 70000 && count != 16'hFFFF; i++) tick(1);
    chk(count == 16'hFFFF, "R5", "reached max", int'(count), 65535);
    tick(1);
    chk(count == 16'h0000 && cen, "R5", "wrap to zero", int'(count), 0);
    tick(2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule